// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the protocol engine on the slave side of a two-wire serial memory that holds 4096 bytes. A bus front end turns the SCL and SDA pads into single-cycle strobes: a START strobe, a STOP strobe, a bit strobe carrying the SDA level sampled at each SCL rise, and an SCL-fall strobe. The engine works on these strobes. It decodes the control byte and the two address bytes, and it drives SDA low to acknowledge. During a read it shifts bytes out with the most significant bit first, taken from a synchronous memory read port. During a write it passes each received byte, together with its target address, to a page-write controller.

The engine expects the front-end strobes to arrive at least three clock cycles apart. This spacing leaves room for the two-cycle memory read that loads each outgoing byte. A random read is done by writing only the two address bytes, then sending a repeated START and a control byte with the read bit set. The address pointer survives across START and STOP, so a read that follows continues from the last location touched.

Write bytes leave through a valid/ready channel. Once `wr_valid` rises, it stays high and `wr_addr`/`wr_data` stay unchanged until a clock edge where `wr_ready` is high. The channel holds one byte. When a data byte completes, the channel must either be empty or be handing off its byte in that same cycle. If it is neither, the new byte is refused with a NACK. The page-write controller watches STOP itself to start programming, and it reports that programming through `prog_busy`.

Top module: `eep_slave_engine`

## Requirements
- R1: The control byte is acknowledged only when bits 7:4 equal 1010 and bits 3:1 equal `strap_sel`. Bit 0 = 1 selects a read and bit 0 = 0 selects a write. If the control byte is refused, every later byte is also refused until the next START.
- R2: An acknowledge drives SDA low starting on the cycle after the SCL fall that follows the eighth bit. It stays low through the whole ninth clock and is released on the cycle after the next SCL fall.
- R3: In a write, the high address byte comes first and the low byte second, each sent most significant bit first. If bits 7:4 of the high byte are not zero, that byte is refused and the rest of the transfer is ignored.
- R4: Each acknowledged data byte appears on the write channel with the address it targets. `wr_valid`, `wr_addr` and `wr_data` are held until a cycle where `wr_ready` is high.
- R5: After each data byte, the write address advances only within its 32-byte page. Address bits 4:0 wrap around and the upper bits stay the same, so 0xFFF is followed by 0xFE0.
- R6: A data byte that completes while the write channel still holds a byte, with `wr_ready` low, is refused and dropped, and the rest of the transfer is ignored. If `wr_ready` is high in that same cycle, the new byte is acknowledged and takes the freed slot.
- R7: Read bytes are sent most significant bit first, with a data bit of 0 shown as SDA driven low. SDA changes only on the cycle after an SCL-fall strobe, a START or a STOP.
- R8: A sequential read moves to the next address after each byte and wraps from 0xFFF to 0x000. Each byte is fetched with a single-cycle `mem_rd_en` pulse.
- R9: When the master sends NACK (bit value 1 on the ninth clock) after a read byte, the engine releases SDA and drives nothing more until the next START.
- R10: The address pointer is kept across a repeated START and across STOP. A read that follows the two address bytes starts at the address they loaded, and a later read continues after the last byte read.
- R11: While `prog_busy` is high when a byte completes, that byte gets no acknowledge, whatever kind of byte it is, and no write is issued.
- R12: A START at any point, including in the middle of a byte, releases SDA and restarts control-byte decoding. A STOP at any point releases SDA and ignores bits until the next START.
- R13: After reset, SDA is released, `wr_valid` and `mem_rd_en` are low, and the address pointer is 0x000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_evt | input | 1 | START or repeated START detected (one-cycle strobe) |
| stop_evt | input | 1 | STOP detected (one-cycle strobe) |
| bit_valid | input | 1 | SCL rose; `bit_value` holds the sampled SDA level |
| bit_value | input | 1 | SDA level sampled at the SCL rise |
| scl_fall | input | 1 | SCL fell (one-cycle strobe) |
| strap_sel | input | 3 | Chip-select strap levels |
| prog_busy | input | 1 | Page-write controller is programming the array |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |
| mem_rd_en | output | 1 | Memory read request; data is expected on the following cycle |
| mem_rd_addr | output | ADDR_W | Memory read address |
| mem_rd_data | input | 8 | Memory read data |
| wr_valid | output | 1 | A write byte is offered |
| wr_ready | input | 1 | Page-write controller takes the offered byte |
| wr_addr | output | ADDR_W | Target address of the offered byte |
| wr_data | output | 8 | Offered byte |

## Verification
Two things can happen in the same cycle: the write channel hands off the byte it is holding, and the next data byte completes on its eighth bit strobe. The bench raises `wr_ready` in exactly the cycle of that eighth strobe. It then expects an acknowledge on SDA, and it expects the channel to now hold the new byte at the next address within the page. A second run leaves `wr_ready` low and expects a NACK, with the old byte and address unchanged. Together these two runs show that freeing the slot and filling it are handled in the same edge.

// File: rtl/eep_pkg.sv
package eep_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CTRL,
    PH_AHI,
    PH_ALO,
    PH_WDAT,
    PH_RDAT,
    PH_HOLD
  } phase_t;

  // Outcome of judging one completed incoming byte
  typedef struct packed {
    logic   ack;
    phase_t nxt;
    logic   load_hi;
    logic   load_ptr;
    logic   push;
    logic   fetch;
  } verdict_t;

endpackage

// File: rtl/eep_byte_judge.sv
module eep_byte_judge
  import eep_pkg::*;
#(
  parameter int         ADDR_W    = 12,
  parameter logic [3:0] CTRL_CODE = 4'b1010
) (
  input  phase_t     phase,
  input  logic [7:0] byte_in,
  input  logic [2:0] strap,
  input  logic       busy,
  input  logic       slot_free,
  output verdict_t   verdict
);
  localparam int HI_W  = ADDR_W - 8;
  localparam int PAD_W = 8 - HI_W;

  always_comb begin
    verdict     = '0;
    verdict.nxt = PH_HOLD;
    if (!busy) begin
      case (phase)
        PH_CTRL: begin
          if (byte_in[7:4] == CTRL_CODE && byte_in[3:1] == strap) begin
            verdict.ack = 1'b1;
            if (byte_in[0]) begin
              verdict.nxt   = PH_RDAT;
              verdict.fetch = 1'b1;
            end else begin
              verdict.nxt = PH_AHI;
            end
          end
        end
        PH_AHI: begin
          if (byte_in[7 -: PAD_W] == '0) begin
            verdict.ack     = 1'b1;
            verdict.load_hi = 1'b1;
            verdict.nxt     = PH_ALO;
          end
        end
        PH_ALO: begin
          verdict.ack      = 1'b1;
          verdict.load_ptr = 1'b1;
          verdict.nxt      = PH_WDAT;
        end
        PH_WDAT: begin
          if (slot_free) begin
            verdict.ack  = 1'b1;
            verdict.push = 1'b1;
            verdict.nxt  = PH_WDAT;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/eep_addr_ptr.sv
module eep_addr_ptr #(
  parameter int ADDR_W     = 12,
  parameter int PAGE_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_hi,
  input  logic              load_ptr,
  input  logic              step_page,
  input  logic              step_seq,
  input  logic [7:0]        byte_in,
  output logic [ADDR_W-1:0] ptr
);
  localparam int HI_W   = ADDR_W - 8;
  localparam int PAGE_W = $clog2(PAGE_BYTES);
  localparam logic [ADDR_W-1:0] A_ONE = 1;

  logic [HI_W-1:0]   hi_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [ADDR_W-1:0] page_next;

  generate
    if (PAGE_W < ADDR_W) begin : g_page
      localparam logic [PAGE_W-1:0] P_ONE = 1;
      assign page_next = {ptr_q[ADDR_W-1:PAGE_W], ptr_q[PAGE_W-1:0] + P_ONE};
    end else begin : g_flat
      assign page_next = ptr_q + A_ONE;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= '0;
      ptr_q <= '0;
    end else begin
      if (load_hi)        hi_q  <= byte_in[HI_W-1:0];
      if (load_ptr)       ptr_q <= {hi_q, byte_in};
      else if (step_page) ptr_q <= page_next;
      else if (step_seq)  ptr_q <= ptr_q + A_ONE;
    end
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/eep_tx_shift.sv
module eep_tx_shift (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] din,
  input  logic       shift,
  output logic       msb
);
  logic [7:0] tx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     tx_q <= '0;
    else if (load)  tx_q <= din;
    else if (shift) tx_q <= {tx_q[6:0], 1'b0};
  end

  assign msb = tx_q[7];
endmodule

// File: rtl/eep_wr_slot.sv
module eep_wr_slot #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [7:0]        push_data,
  input  logic              wr_ready,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              slot_free
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else if (push) begin
      wr_valid <= 1'b1;
      wr_addr  <= push_addr;
      wr_data  <= push_data;
    end else if (wr_ready) begin
      wr_valid <= 1'b0;
    end
  end

  assign slot_free = !wr_valid || wr_ready;
endmodule

// File: rtl/eep_slave_engine.sv
module eep_slave_engine #(
  parameter int         ADDR_W     = 12,
  parameter int         PAGE_BYTES = 32,
  parameter logic [3:0] CTRL_CODE  = 4'b1010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              bit_valid,
  input  logic              bit_value,
  input  logic              scl_fall,
  input  logic [2:0]        strap_sel,
  input  logic              prog_busy,
  output logic              sda_drive_low,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [7:0]        mem_rd_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data
);
  import eep_pkg::*;

  phase_t            phase, nxt_q;
  logic [3:0]        bitcnt;
  logic [6:0]        rx_q;
  logic              ack_q, sda_q, rd_q, rd_dly;
  logic [7:0]        byte_now;
  logic [ADDR_W-1:0] ptr;
  logic              slot_free, tx_msb;
  verdict_t          verdict;
  logic              quiet, receiving, byte_done, tx_done8, out_fall;

  assign quiet     = !start_evt && !stop_evt;
  assign receiving = (phase == PH_CTRL) || (phase == PH_AHI) ||
                     (phase == PH_ALO)  || (phase == PH_WDAT);
  assign byte_now  = {rx_q, bit_value};
  assign byte_done = quiet && bit_valid && receiving && (bitcnt == 4'd7);
  assign tx_done8  = quiet && bit_valid && (phase == PH_RDAT) && (bitcnt == 4'd7);
  assign out_fall  = quiet && scl_fall &&
                     ((receiving && bitcnt == 4'd10 && nxt_q == PH_RDAT) ||
                      (phase == PH_RDAT &&
                       ((bitcnt >= 4'd1 && bitcnt <= 4'd7) || bitcnt == 4'd10)));

  eep_byte_judge #(.ADDR_W(ADDR_W), .CTRL_CODE(CTRL_CODE)) u_judge (
    .phase    (phase),
    .byte_in  (byte_now),
    .strap    (strap_sel),
    .busy     (prog_busy),
    .slot_free(slot_free),
    .verdict  (verdict)
  );

  eep_addr_ptr #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_hi  (byte_done && verdict.load_hi),
    .load_ptr (byte_done && verdict.load_ptr),
    .step_page(byte_done && verdict.push),
    .step_seq (tx_done8),
    .byte_in  (byte_now),
    .ptr      (ptr)
  );

  eep_tx_shift u_tx (
    .clk  (clk),
    .rst_n(rst_n),
    .load (rd_dly),
    .din  (mem_rd_data),
    .shift(out_fall),
    .msb  (tx_msb)
  );

  eep_wr_slot #(.ADDR_W(ADDR_W)) u_slot (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (byte_done && verdict.push),
    .push_addr(ptr),
    .push_data(byte_now),
    .wr_ready (wr_ready),
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .slot_free(slot_free)
  );

  // Read fetch: request one cycle after the pointer settles, load the byte the cycle after
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= 1'b0;
      rd_dly <= 1'b0;
    end else begin
      rd_q   <= (byte_done && verdict.fetch) || tx_done8;
      rd_dly <= rd_q;
    end
  end

  // Bit counter: 0..7 data bits, 8 byte done, 9 ninth clock low->high, 10 ninth clock high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      nxt_q  <= PH_IDLE;
      bitcnt <= '0;
      rx_q   <= '0;
      ack_q  <= 1'b0;
      sda_q  <= 1'b0;
    end else if (start_evt) begin
      phase  <= PH_CTRL;
      bitcnt <= '0;
      sda_q  <= 1'b0;
    end else if (stop_evt) begin
      phase  <= PH_IDLE;
      bitcnt <= '0;
      sda_q  <= 1'b0;
    end else if (receiving) begin
      if (bit_valid) begin
        if (bitcnt < 4'd8) begin
          rx_q   <= byte_now[6:0];
          bitcnt <= bitcnt + 4'd1;
          if (bitcnt == 4'd7) begin
            ack_q <= verdict.ack;
            nxt_q <= verdict.nxt;
          end
        end else if (bitcnt == 4'd9) begin
          bitcnt <= 4'd10;
        end
      end else if (scl_fall) begin
        if (bitcnt == 4'd8) begin
          bitcnt <= 4'd9;
          sda_q  <= ack_q;
        end else if (bitcnt == 4'd10) begin
          bitcnt <= '0;
          phase  <= nxt_q;
          sda_q  <= (nxt_q == PH_RDAT) ? !tx_msb : 1'b0;
        end
      end
    end else if (phase == PH_RDAT) begin
      if (bit_valid) begin
        if (bitcnt < 4'd8) begin
          bitcnt <= bitcnt + 4'd1;
        end else if (bitcnt == 4'd9) begin
          if (!bit_value) begin
            bitcnt <= 4'd10;
          end else begin
            bitcnt <= '0;
            phase  <= PH_HOLD;
          end
        end
      end else if (scl_fall) begin
        if ((bitcnt >= 4'd1 && bitcnt <= 4'd7) || bitcnt == 4'd10) begin
          sda_q <= !tx_msb;
          if (bitcnt == 4'd10) bitcnt <= '0;
        end else if (bitcnt == 4'd8) begin
          sda_q  <= 1'b0;
          bitcnt <= 4'd9;
        end
      end
    end
  end

  assign sda_drive_low = sda_q;
  assign mem_rd_en     = rd_q;
  assign mem_rd_addr   = ptr;
endmodule

// File: rtl/eep_slave_checker.sv
module eep_slave_checker #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_evt,
  input logic              stop_evt,
  input logic              scl_fall,
  input logic              sda_drive_low,
  input logic              mem_rd_en,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data
);
  // R7
  sda_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_drive_low) |-> $past(scl_fall || start_evt || stop_evt));

  // R4
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  // R8
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);

  // R12
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_drive_low);

  // R12
  start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !sda_drive_low);
endmodule

bind eep_slave_engine eep_slave_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_evt    (start_evt),
  .stop_evt     (stop_evt),
  .scl_fall     (scl_fall),
  .sda_drive_low(sda_drive_low),
  .mem_rd_en    (mem_rd_en),
  .wr_valid     (wr_valid),
  .wr_ready     (wr_ready),
  .wr_addr      (wr_addr),
  .wr_data      (wr_data)
);

// File: tb/eep_slave_engine_test.sv
module eep_slave_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_evt = 1'b0, stop_evt = 1'b0, bit_valid = 1'b0, bit_value = 1'b0;
  logic        scl_fall = 1'b0, prog_busy = 1'b0, wr_ready = 1'b0;
  logic [2:0]  strap_sel = 3'b101;
  logic        sda_drive_low, mem_rd_en, wr_valid;
  logic [11:0] mem_rd_addr, wr_addr;
  logic [7:0]  mem_rd_data = 8'h00, wr_data;
  int          checks = 0, errors = 0;

  always #10 clk = ~clk;

  eep_slave_engine uut (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .stop_evt(stop_evt),
    .bit_valid(bit_valid), .bit_value(bit_value), .scl_fall(scl_fall),
    .strap_sel(strap_sel), .prog_busy(prog_busy), .sda_drive_low(sda_drive_low),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  function automatic logic [7:0] mem_fn(input logic [11:0] a);
    return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'h5A;
  endfunction

  always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem_fn(mem_rd_addr);

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_fall;
    @(negedge clk) scl_fall = 1'b1;
    @(negedge clk) scl_fall = 1'b0;
    idle(3);
  endtask

  task automatic do_rise(input logic b, input logic rdy);
    @(negedge clk) begin bit_valid = 1'b1; bit_value = b; wr_ready = rdy; end
    @(negedge clk) begin bit_valid = 1'b0; wr_ready = 1'b0; end
    idle(3);
  endtask

  task automatic do_start;
    @(negedge clk) start_evt = 1'b1;
    @(negedge clk) start_evt = 1'b0;
    idle(3);
    do_fall();
  endtask

  task automatic do_stop;
    @(negedge clk) stop_evt = 1'b1;
    @(negedge clk) stop_evt = 1'b0;
    idle(3);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic rdy_last, output logic acked, output logic rel);
    logic a0, a1;
    for (int i = 7; i >= 0; i--) begin
      do_rise(b[i], (i == 0) && rdy_last);
      do_fall();
    end
    a0 = sda_drive_low;
    do_rise(1'b1, 1'b0);
    a1 = sda_drive_low;
    do_fall();
    acked = a0 && a1;
    rel = !sda_drive_low;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b, output logic rel);
    for (int i = 7; i >= 0; i--) begin
      b[i] = !sda_drive_low;
      do_rise(1'b1, 1'b0);
      do_fall();
    end
    rel = !sda_drive_low;
    do_rise(!mack, 1'b0);
    do_fall();
  endtask

  task automatic accept;
    @(negedge clk) wr_ready = 1'b1;
    @(negedge clk) wr_ready = 1'b0;
    idle(1);
  endtask

  task automatic t_reset_state;
    logic a, r;
    logic [7:0] d;
    chk("R13", "sda after reset", sda_drive_low, 0);
    chk("R13", "wr_valid after reset", wr_valid, 0);
    chk("R13", "mem_rd_en after reset", mem_rd_en, 0);
    do_start();
    send_byte(8'hAB, 1'b0, a, r);
    chk("R1", "read control ack", a, 1);
    recv_byte(1'b0, d, r);
    chk("R13", "pointer 0 read data", d, mem_fn(12'h000));
    do_stop();
  endtask

  task automatic t_page_write;
    logic a, r;
    do_start();
    send_byte(8'hAA, 1'b0, a, r);
    chk("R1", "write control ack", a, 1);
    chk("R2", "ack released after ninth clock", r, 1);
    send_byte(8'h0F, 1'b0, a, r);
    chk("R3", "high address ack", a, 1);
    send_byte(8'hFE, 1'b0, a, r);
    chk("R3", "low address ack", a, 1);
    send_byte(8'h11, 1'b0, a, r);
    chk("R4", "data ack", a, 1);
    chk("R4", "wr_valid", wr_valid, 1);
    chk("R4", "wr_addr", wr_addr, 12'hFFE);
    chk("R4", "wr_data", wr_data, 8'h11);
    accept();
    chk("R4", "wr_valid after handshake", wr_valid, 0);
    send_byte(8'h22, 1'b0, a, r);
    chk("R5", "second addr", wr_addr, 12'hFFF);
    accept();
    send_byte(8'h33, 1'b0, a, r);
    chk("R5", "page wrap addr", wr_addr, 12'hFE0);
    chk("R5", "page wrap data", wr_data, 8'h33);
    accept();
    do_stop();
    chk("R12", "sda after stop", sda_drive_low, 0);
  endtask

  task automatic t_random_read;
    logic a, r;
    logic [7:0] d;
    int drove;
    do_start();
    send_byte(8'hAA, 1'b0, a, r);
    send_byte(8'h0F, 1'b0, a, r);
    send_byte(8'hFE, 1'b0, a, r);
    do_start();
    send_byte(8'hAB, 1'b0, a, r);
    chk("R10", "read control ack after repeated start", a, 1);
    recv_byte(1'b1, d, r);
    chk("R10", "first read at loaded addr", d, mem_fn(12'hFFE));
    chk("R7", "sda released for master ack", r, 1);
    recv_byte(1'b1, d, r);
    chk("R8", "sequential byte", d, mem_fn(12'hFFF));
    recv_byte(1'b0, d, r);
    chk("R8", "wrap to 000", d, mem_fn(12'h000));
    chk("R9", "sda released after nack", sda_drive_low, 0);
    drove = 0;
    for (int i = 0; i < 9; i++) begin
      do_rise(1'b1, 1'b0);
      if (sda_drive_low) drove++;
      do_fall();
      if (sda_drive_low) drove++;
    end
    chk("R9", "no drive after nack", drove, 0);
    do_stop();
    do_start();
    send_byte(8'hAB, 1'b0, a, r);
    recv_byte(1'b0, d, r);
    chk("R10", "current read continues", d, mem_fn(12'h001));
    do_stop();
  endtask

  task automatic t_bad_select;
    logic a, r;
    do_start();
    send_byte(8'hA8, 1'b0, a, r);
    chk("R1", "wrong strap nack", a, 0);
    send_byte(8'hAA, 1'b0, a, r);
    chk("R1", "ignored until start", a, 0);
    do_stop();
    do_start();
    send_byte(8'hBA, 1'b0, a, r);
    chk("R1", "wrong code nack", a, 0);
    do_stop();
  endtask

  task automatic t_addr_high;
    logic a, r;
    do_start();
    send_byte(8'hAA, 1'b0, a, r);
    send_byte(8'h10, 1'b0, a, r);
    chk("R3", "nonzero upper nibble nack", a, 0);
    send_byte(8'h00, 1'b0, a, r);
    chk("R3", "rest ignored", a, 0);
    send_byte(8'h5C, 1'b0, a, r);
    chk("R3", "no write issued", wr_valid, 0);
    do_stop();
  endtask

  task automatic t_busy;
    logic a, r;
    prog_busy = 1'b1;
    do_start();
    send_byte(8'hAA, 1'b0, a, r);
    chk("R11", "control nack while busy", a, 0);
    do_stop();
    prog_busy = 1'b0;
    do_start();
    send_byte(8'hAA, 1'b0, a, r);
    send_byte(8'h00, 1'b0, a, r);
    send_byte(8'h40, 1'b0, a, r);
    prog_busy = 1'b1;
    send_byte(8'h77, 1'b0, a, r);
    chk("R11", "data nack while busy", a, 0);
    chk("R11", "no write while busy", wr_valid, 0);
    prog_busy = 1'b0;
    do_stop();
  endtask

  task automatic t_backpressure;
    logic a, r;
    do_start();
    send_byte(8'hAA, 1'b0, a, r);
    send_byte(8'h00, 1'b0, a, r);
    send_byte(8'h40, 1'b0, a, r);
    send_byte(8'h55, 1'b0, a, r);
    chk("R4", "first byte ack", a, 1);
    send_byte(8'h66, 1'b0, a, r);
    chk("R6", "full slot nack", a, 0);
    chk("R6", "held data kept", wr_data, 8'h55);
    chk("R6", "held addr kept", wr_addr, 12'h040);
    accept();
    do_stop();
  endtask

  task automatic t_same_cycle;
    logic a, r;
    do_start();
    send_byte(8'hAA, 1'b0, a, r);
    send_byte(8'h00, 1'b0, a, r);
    send_byte(8'h60, 1'b0, a, r);
    send_byte(8'h81, 1'b0, a, r);
    send_byte(8'h82, 1'b1, a, r);
    chk("R6", "ack when slot freed same cycle", a, 1);
    chk("R6", "new byte in slot", wr_data, 8'h82);
    chk("R6", "new byte addr", wr_addr, 12'h061);
    chk("R6", "slot valid", wr_valid, 1);
    accept();
    do_stop();
  endtask

  task automatic t_abort;
    logic a, r;
    do_start();
    do_rise(1'b1, 1'b0); do_fall();
    do_rise(1'b0, 1'b0); do_fall();
    do_rise(1'b1, 1'b0); do_fall();
    do_start();
    send_byte(8'hAA, 1'b0, a, r);
    chk("R12", "start mid byte restarts decode", a, 1);
    do_rise(1'b0, 1'b0); do_fall();
    do_rise(1'b0, 1'b0); do_fall();
    do_stop();
    send_byte(8'hAA, 1'b0, a, r);
    chk("R12", "bits after stop ignored", a, 0);
    do_start();
    for (int i = 7; i >= 0; i--) begin
      do_rise(i[0] ? 1'b1 : 1'b0, 1'b0);
      do_fall();
    end
    chk("R2", "ack driven in ninth clock", sda_drive_low, 1);
    do_stop();
    chk("R12", "stop during ack releases", sda_drive_low, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(2);
    t_reset_state();
    t_page_write();
    t_random_read();
    t_bad_select();
    t_addr_high();
    t_busy();
    t_backpressure();
    t_same_cycle();
    t_abort();
    idle(5);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule